// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block serialises bytes onto a single asynchronous line. The frame format comes from an 8-bit line control register that is loaded through a one-cycle write strobe. The format covers the word length, the number of stop bits, whether a parity bit is sent, and how that parity bit is formed. Bytes arrive on a valid/ready handshake. Bit timing is driven by a tick enable that an external baud divider supplies. Each bit on the line lasts a fixed number of ticks.

A break control forces the line low for as long as it is set, and it takes effect at once. While break is set the frame engine keeps running underneath, so handshake timing is the same with or without break. The most significant register bit is a divisor-access flag. This block only drives it out for the surrounding register map and does not use it for framing.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx_o is 1, ready_o is 1 and divisor_access_o is 0. All register bits are 0, which gives 5 data bits, 1 stop bit, no parity and no break.
- R2: Register bits 1:0 select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least significant bit first, and only the low bits of the byte that fit the word length are sent.
- R3: The idle line is 1. A frame starts with one start bit at 0 and ends with stop bits at 1. With TICKS_PER_BIT = 16, every start, data and parity bit lasts 16 baud ticks.
- R4: Register bit 2 = 0 gives 16 ticks of stop. Bit 2 = 1 gives 24 ticks (1.5 bits) for 5-bit words and 32 ticks (2 bits) for the other word lengths.
- R5: Register bit 3 = 1 inserts one parity bit after the data bits. Bit 3 = 0 inserts none.
- R6: With parity on and bit 5 = 0, bit 4 = 0 gives odd parity: the data bits plus the parity bit hold an odd number of ones. Bit 4 = 1 gives even parity.
- R7: With parity on and bit 5 = 1, the parity bit is a constant: 1 when bit 4 = 0, and 0 when bit 4 = 1.
- R8: Register bit 6 = 1 drives tx_o to 0 from the cycle after the write until the cycle after a write clears it. This holds both in idle and mid-frame. The frame still runs underneath, and ready_o timing is unchanged.
- R9: Register bit 7 appears on divisor_access_o from the cycle after the write. It has no effect on the frame.
- R10: The format is captured when a byte is accepted. A register write during a frame changes only later frames.
- R11: A byte is accepted on a clock edge where valid_i and ready_o are both 1. ready_o is 1 only while no frame is in progress. It drops in the cycle after acceptance and returns in the cycle after the last stop tick.
- R12: Bit timing advances only on cycles where baud_tick_i is 1. A frame lasts exactly its nominal tick count of asserted ticks, whatever the spacing between the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Line control register write strobe |
| reg_wdata_i | input | 8 | Line control register write data |
| baud_tick_i | input | 1 | Tick enable from the baud divider |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i is valid |
| ready_o | output | 1 | Transmitter idle and able to accept a byte |
| tx_o | output | 1 | Serial line |
| divisor_access_o | output | 1 | Divisor-access flag (register bit 7) |

## Verification
A tick counter that is off by one, or a wrong stop limit, shifts every later bit boundary. It also moves the cycle in which ready_o returns, so checking ready_o one cycle before and at the nominal frame end catches it within one frame. A wrong shift position or a wrong parity selection shows up as a wrong level at the middle of the affected bit. The sweep covers every word length, stop setting and parity mode, and samples each bit at its middle. Format latching and break masking are checked by writing the register mid-frame and watching the rest of that frame and the handshake timing.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wlen;
  } tx_fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/uart_tx_lcr.sv
module uart_tx_lcr
  import uart_tx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output tx_fmt_t       fmt_o,
  output logic          brk_o,
  output logic          dlab_o
);
  logic [7:0] lcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lcr_q <= '0;
    else if (we_i) lcr_q <= wdata_i;
  end

  assign fmt_o  = tx_fmt_t'(lcr_q[5:0]);
  assign brk_o  = lcr_q[6];
  assign dlab_o = lcr_q[7];

  AST_LCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(lcr_q)); // R10
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  tx_fmt_t           fmt_i,
  output logic              par_o
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      mask[i] = (i < (MIN_W + int'(fmt_i.wlen)));
    ones_odd = ^(data_i & mask);
    if (fmt_i.stick)     par_o = ~fmt_i.even;
    else if (fmt_i.even) par_o = ones_odd;
    else                 par_o = ~ones_odd;
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MIN_W         = 5,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  tx_fmt_t           fmt_i,
  input  logic              par_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LIM  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_LIM  = CNT_W'(2 * TICKS_PER_BIT - 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic [BIT_W-1:0]  bit_q, last_bit;
  logic [DATA_W-1:0] shreg_q;
  tx_fmt_t           fmt_q;
  logic              par_q;
  logic              accept;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept   = valid_i && ready_o;
  assign last_bit = BIT_W'(MIN_W - 1) + BIT_W'(fmt_q.wlen);

  always_comb begin
    limit = BIT_LIM;
    if (state_q == ST_STOP && fmt_q.stop_long)
      limit = (fmt_q.wlen == 2'd0) ? HALF_LIM : TWO_LIM;
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
    end else if (accept) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= data_i;
      fmt_q   <= fmt_i;
      par_q   <= par_i;
    end else if (state_q != ST_IDLE && tick_i) begin
      if (cnt_q != limit) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (bit_q == last_bit) state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                   bit_q   <= bit_q + 1'b1;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !line_o); // R3
  AST_FMT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(fmt_q)); // R10
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> line_o); // R11
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && state_q != ST_IDLE) |=> ($stable(cnt_q) && $stable(state_q))); // R12
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit); // R4
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              baud_tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              divisor_access_o
);
  localparam int MIN_W = 5;

  tx_fmt_t fmt;
  logic    brk, par, line;

  uart_tx_lcr u_lcr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .fmt_o  (fmt),
    .brk_o  (brk),
    .dlab_o (divisor_access_o)
  );

  uart_tx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
    .data_i(data_i),
    .fmt_i (fmt),
    .par_o (par)
  );

  uart_tx_engine #(.DATA_W(DATA_W), .MIN_W(MIN_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .data_i (data_i),
    .valid_i(valid_i),
    .fmt_i  (fmt),
    .par_i  (par),
    .ready_o(ready_o),
    .line_o (line)
  );

  // break masks the line; the engine keeps running
  assign tx_o = line & ~brk;
endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       tick = 1'b1;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       ready, tx, dlab;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  uart_frame_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .baud_tick_i(tick), .data_i(data), .valid_i(valid),
    .ready_o(ready), .tx_o(tx), .divisor_access_o(dlab)
  );

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_lcr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  function automatic int frame_ticks(input logic [7:0] lv);
    int n = 5 + int'(lv[1:0]);
    int st = !lv[2] ? 16 : (lv[1:0] == 2'd0 ? 24 : 32);
    return 16 * (1 + n + int'(lv[3])) + st;
  endfunction

  function automatic logic exp_par(input logic [7:0] lv, input logic [7:0] d);
    int n = 5 + int'(lv[1:0]);
    logic x = 1'b0;
    for (int i = 0; i < n; i++) x ^= d[i];
    if (lv[5]) return ~lv[4];
    return lv[4] ? x : ~x;
  endfunction

  // sends one byte under lv; optional register write at offset wr_j
  task automatic run_frame(input logic [7:0] lv, input logic [7:0] d,
                           input int wr_j, input logic [7:0] wr_v, input bit skip_prog);
    int n = 5 + int'(lv[1:0]);
    int p = int'(lv[3]);
    int t = frame_ticks(lv);
    bit brk_mid = wr_v[6];
    logic e;
    string tag;
    if (!skip_prog) wr_lcr(lv);
    tick = 1'b1;
    @(negedge clk);
    chk("R11 ready before send", int'(ready), 1);
    data = d; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    for (int j = 0; j <= t; j++) begin
      if (j == wr_j) begin reg_we = 1'b1; reg_wdata = wr_v; end
      if (j == wr_j + 1) reg_we = 1'b0;
      if (j % 16 == 8 && j < t) begin
        int k = j / 16;
        if (k == 0)          begin e = 1'b0;        tag = "R3 start"; end
        else if (k <= n)     begin e = d[k-1];      tag = "R2 data"; end
        else if (p && k == n + 1) begin e = exp_par(lv, d); tag = lv[5] ? "R7 stick parity" : "R6 parity"; end
        else                 begin e = 1'b1;        tag = "R4 stop"; end
        if (wr_j >= 0 && j > wr_j && brk_mid) begin e = 1'b0; tag = "R8 break mid"; end
        else if (wr_j >= 0) tag = {"R10 ", tag};
        chk(tag, int'(tx), int'(e));
      end
      if (j == t - 1) chk("R11 busy at end-1 (R5 R4 length)", int'(ready), 0);
      if (j == t)     chk("R11 ready at frame end", int'(ready), 1);
      if (j < t) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx idle", int'(tx), 1);
    chk("R1 ready", int'(ready), 1);
    chk("R1 dlab", int'(dlab), 0);
    rst_n = 1'b1;
    // R1: default format 5N1 without any write
    run_frame(8'h00, 8'hE6, -1, 8'h00, 1'b1);

    // R2 R4 R5 R6 R7: full sweep of format bits
    for (int lv = 0; lv < 64; lv++) begin
      run_frame(8'(lv), 8'hA5, -1, 8'h00, 1'b0);
      run_frame(8'(lv), 8'h3C, -1, 8'h00, 1'b1);
      run_frame(8'(lv), 8'(lv * 37 + 11), -1, 8'h00, 1'b1);
    end

    // R9: divisor-access flag visible and framing unaffected
    wr_lcr(8'h80);
    @(negedge clk);
    chk("R9 dlab set", int'(dlab), 1);
    chk("R9 line idle", int'(tx), 1);
    run_frame(8'hBB, 8'h96, -1, 8'h00, 1'b0);
    chk("R9 dlab after frame", int'(dlab), 1);

    // R10: mid-frame write of a different format
    run_frame(8'h03, 8'h5A, 20, 8'h1C, 1'b0);
    run_frame(8'h1C, 8'h5A, -1, 8'h00, 1'b1);

    // R8: break mid-frame, then in idle, then release
    run_frame(8'h0B, 8'hC3, 40, 8'h4B, 1'b0);
    chk("R8 break held in idle", int'(tx), 0);
    wr_lcr(8'h0B);
    @(negedge clk);
    chk("R8 break released", int'(tx), 1);
    wr_lcr(8'h40);
    chk("R8 break in idle", int'(tx), 0);
    wr_lcr(8'h00);
    chk("R8 break cleared", int'(tx), 1);

    // R12: sparse ticks, one every third cycle
    begin
      int t = frame_ticks(8'h07);
      int cnt = 0;
      int j = 0;
      wr_lcr(8'h07);
      @(negedge clk); tick = 1'b0; data = 8'h81; valid = 1'b1;
      @(negedge clk); valid = 1'b0;
      while (!ready && j < 4 * t) begin
        tick = (j % 3 == 0);
        if (tick) cnt++;
        @(negedge clk);
        j++;
      end
      chk("R12 ready after sparse ticks", int'(ready), 1);
      chk("R12 tick count", cnt, t);
      tick = 1'b1;
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule